// File: doc/BRIEF.md
# Two-Level Page Table Walker with Translation Cache

This block turns 32-bit device virtual addresses into physical addresses. A request names a virtual address and the stream it belongs to. The block first looks in a small fully associative translation cache. On a miss it reads two 32-bit page table entries from memory, one at a time. The first entry comes from a first-level table selected by a base register. The second comes from the second-level table that the first entry names. The result is returned on a response port and, when allowed, stored in the cache.

Pages are 4 KiB. The top ten virtual address bits pick the first-level entry, the next ten pick the second-level entry, and the low twelve bits pass through as the page offset. An entry holds only a page frame number. No entry is ever treated as invalid: software points unused slots at a shared placeholder table or page, so every walk completes. Three registers control the block. One holds the first-level table base as a frame number. One takes a stream bitmask and drops the matching cached translations. One holds configuration bits, of which bit 0 turns the cache off.

Top module: `pgw_top`

## Requirements
- R1: After reset, `req_ready` is 1, `mem_rd_valid` and `rsp_valid` are 0, and the base and configuration registers read 0. The translation cache is empty, so the first request misses.
- R2: On a miss, the first memory read is at address {base frame (27 bits), vaddr[31:22], 2'b00}. That address stays steady while `mem_rd_ready` is low.
- R3: The second memory read is at address {first entry[26:0], vaddr[21:12], 2'b00}. Entry bits 31:27 are ignored.
- R4: A walk's response comes in the cycle after the second entry arrives. The response carries `rsp_paddr` = {second entry[26:0], vaddr[11:0]}, `rsp_hit`=0 and `rsp_err`=0, and `rsp_valid` is high for exactly one cycle.
- R5: A request whose page is cached gets its response in the cycle after the lookup cycle. The response has `rsp_hit`=1 and the cached frame, and no memory read is issued.
- R6: The cache holds 8 translations tagged by vaddr[31:12]. Fills take slots in strict rotation, whether or not a slot is valid, so the ninth distinct fill evicts the first.
- R7: A write to offset 0x0 drops every cached translation whose stream ID (`req_sid`) has its bit set in the written mask. Other translations stay, and a mask of 0 changes nothing.
- R8: A write to offset 0x0 while a walk is in progress does not stop the walk or change its result, but that result is not cached.
- R9: At most one memory read is outstanding. After a read is accepted, `mem_rd_valid` stays low until its data returns.
- R10: When bit 0 of the configuration register (offset 0x8) is 1, every request walks memory and nothing is cached. Translations cached before that are kept.
- R11: A memory error on either fetch ends the walk. The response then has `rsp_err`=1 and `rsp_paddr`=0, and nothing is cached.
- R12: Offset 0x4 keeps the low 27 bits of a write and reads them back zero-extended. Offset 0x8 keeps all 32 bits. Offset 0x0 reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register byte offset (0x0 flush mask, 0x4 base frame, 0x8 configuration) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block is idle and takes a request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_sid | input | 5 | Stream ID of the request |
| rsp_valid | output | 1 | Response present for one cycle |
| rsp_paddr | output | 39 | Translated physical address |
| rsp_hit | output | 1 | Response came from the cache |
| rsp_err | output | 1 | Walk ended by a memory error |
| mem_rd_valid | output | 1 | Table entry read request |
| mem_rd_ready | input | 1 | Memory takes the read |
| mem_rd_addr | output | 39 | Byte address of the table entry |
| mem_rsp_valid | input | 1 | Entry data present |
| mem_rsp_data | input | 32 | Table entry |
| mem_rsp_err | input | 1 | Entry fetch failed |

## Verification
A request is taken at the clock edge where `req_valid` and `req_ready` are both high. The next cycle is the lookup cycle. A hit responds one cycle after that. A miss raises `mem_rd_valid` one cycle after the lookup cycle. Each read is accepted at the edge where the bench raises `mem_rd_ready`. Each returned entry moves the walk on at the edge where it is presented: the second read appears, or the response appears, in the following cycle. The bench changes inputs and samples outputs on falling edges. It checks each of those cycles against a behavioural model of the cache (valid flags, tags, stream IDs and a rotating slot counter). From that model it predicts hit or miss, both fetch addresses and the returned address. It also checks that no read is requested during stall and latency cycles.

// File: rtl/pgw_pkg.sv
package pgw_pkg;
    localparam int VA_W   = 32;
    localparam int OFF_W  = 12;
    localparam int IDX_W  = 10;
    localparam int VPN_W  = VA_W - OFF_W;
    localparam int PFN_W  = 27;
    localparam int PA_W   = PFN_W + OFF_W;
    localparam int SID_W  = 5;
    localparam int NSTRM  = 1 << SID_W;
    localparam int RA_W   = 4;

    localparam logic [RA_W-1:0] OFS_FLUSH = 4'h0;
    localparam logic [RA_W-1:0] OFS_BASE  = 4'h4;
    localparam logic [RA_W-1:0] OFS_CFG   = 4'h8;

    typedef logic [VPN_W-1:0] vpn_t;
    typedef logic [PFN_W-1:0] pfn_t;
    typedef logic [SID_W-1:0] sid_t;

    typedef struct packed {
        logic valid;
        vpn_t vpn;
        pfn_t pfn;
        sid_t sid;
    } tlb_ent_t;

    typedef enum logic [2:0] {
        ST_IDLE, ST_LOOKUP, ST_L1, ST_L2, ST_RESP
    } walk_st_t;

    function automatic logic [PA_W-1:0] entry_addr(input pfn_t tbl, input logic [IDX_W-1:0] idx);
        return {tbl, idx, 2'b00};
    endfunction
endpackage

// File: rtl/pgw_regs.sv
module pgw_regs
    import pgw_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            wr,
    input  logic [RA_W-1:0] addr,
    input  logic [31:0]     wdata,
    output logic [31:0]     rdata,
    output pfn_t            base_pfn,
    output logic [31:0]     cfg,
    output logic            flush_en,
    output logic [NSTRM-1:0] flush_mask
);
    always_ff @(posedge clk) begin
        if (rst) begin
            base_pfn <= '0;
            cfg      <= '0;
        end else if (wr) begin
            if (addr == OFS_BASE) base_pfn <= wdata[PFN_W-1:0];
            if (addr == OFS_CFG)  cfg      <= wdata;
        end
    end

    assign flush_en   = wr && (addr == OFS_FLUSH);
    assign flush_mask = wdata[NSTRM-1:0];

    always_comb begin
        unique case (addr)
            OFS_BASE: rdata = {{(32-PFN_W){1'b0}}, base_pfn};
            OFS_CFG:  rdata = cfg;
            default:  rdata = '0;
        endcase
    end

    // R12: base holds the low 27 bits of the last write
    assert_base_keep_R12: assert property (@(posedge clk) disable iff (rst)
        $past(wr && addr == OFS_BASE) |-> base_pfn == $past(wdata[PFN_W-1:0]));
endmodule

// File: rtl/pgw_tlb.sv
module pgw_tlb
    import pgw_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  vpn_t             lk_vpn,
    output logic             lk_hit,
    output pfn_t             lk_pfn,
    input  logic             fill_en,
    input  vpn_t             fill_vpn,
    input  pfn_t             fill_pfn,
    input  sid_t             fill_sid,
    input  logic             flush_en,
    input  logic [NSTRM-1:0] flush_mask
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    tlb_ent_t             ent_q [DEPTH];
    logic [PTR_W-1:0]     ptr_q;
    logic [DEPTH-1:0]     hit_vec;
    logic [DEPTH-1:0]     valid_vec;

    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign hit_vec[g]   = ent_q[g].valid && (ent_q[g].vpn == lk_vpn);
        assign valid_vec[g] = ent_q[g].valid;
    end

    always_comb begin
        lk_pfn = '0;
        for (int i = 0; i < DEPTH; i++)
            if (hit_vec[i]) lk_pfn = lk_pfn | ent_q[i].pfn;
    end
    assign lk_hit = |hit_vec;

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
            for (int i = 0; i < DEPTH; i++) ent_q[i] <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (fill_en && ptr_q == PTR_W'(i))
                    ent_q[i] <= '{valid: 1'b1, vpn: fill_vpn, pfn: fill_pfn, sid: fill_sid};
                else if (flush_en && flush_mask[ent_q[i].sid])
                    ent_q[i].valid <= 1'b0;
            end
            if (fill_en)
                ptr_q <= (ptr_q == PTR_W'(DEPTH-1)) ? '0 : ptr_q + 1'b1;
        end
    end

    // R6: one page is never cached twice
    assert_unique_tag_R6: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hit_vec));
    // R7: a full mask empties the cache
    assert_flush_all_R7: assert property (@(posedge clk) disable iff (rst)
        (flush_en && (&flush_mask) && !fill_en) |=> (valid_vec == '0));
endmodule

// File: rtl/pgw_top.sv
module pgw_top
    import pgw_pkg::*;
#(
    parameter int TLB_DEPTH = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  reg_wr,
    input  logic [RA_W-1:0]       reg_addr,
    input  logic [31:0]           reg_wdata,
    output logic [31:0]           reg_rdata,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic [VA_W-1:0]       req_vaddr,
    input  logic [SID_W-1:0]      req_sid,
    output logic                  rsp_valid,
    output logic [PA_W-1:0]       rsp_paddr,
    output logic                  rsp_hit,
    output logic                  rsp_err,
    output logic                  mem_rd_valid,
    input  logic                  mem_rd_ready,
    output logic [PA_W-1:0]       mem_rd_addr,
    input  logic                  mem_rsp_valid,
    input  logic [31:0]           mem_rsp_data,
    input  logic                  mem_rsp_err
);
    walk_st_t          st_q;
    logic [VA_W-1:0]   va_q;
    sid_t              sid_q;
    pfn_t              l1_pfn_q;
    logic              issued_q;
    logic              flushed_q;
    logic [PA_W-1:0]   pa_q;
    logic              hit_q;
    logic              err_q;

    pfn_t              base_pfn;
    logic [31:0]       cfg;
    logic              flush_en;
    logic [NSTRM-1:0]  flush_mask;
    logic              tlb_hit;
    pfn_t              tlb_pfn;
    logic              fill_en;
    logic              bypass;
    logic              data_in;
    logic              unused_pte_hi;

    assign bypass        = cfg[0];
    assign unused_pte_hi = ^mem_rsp_data[31:PFN_W];
    assign data_in       = issued_q && mem_rsp_valid;

    pgw_regs u_regs (
        .clk(clk), .rst(rst), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
        .rdata(reg_rdata), .base_pfn(base_pfn), .cfg(cfg),
        .flush_en(flush_en), .flush_mask(flush_mask)
    );

    assign fill_en = (st_q == ST_L2) && data_in && !mem_rsp_err
                     && !bypass && !flushed_q && !flush_en;

    pgw_tlb #(.DEPTH(TLB_DEPTH)) u_tlb (
        .clk(clk), .rst(rst),
        .lk_vpn(va_q[VA_W-1:OFF_W]), .lk_hit(tlb_hit), .lk_pfn(tlb_pfn),
        .fill_en(fill_en), .fill_vpn(va_q[VA_W-1:OFF_W]),
        .fill_pfn(mem_rsp_data[PFN_W-1:0]), .fill_sid(sid_q),
        .flush_en(flush_en), .flush_mask(flush_mask)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= ST_IDLE;
            va_q      <= '0;
            sid_q     <= '0;
            l1_pfn_q  <= '0;
            issued_q  <= 1'b0;
            flushed_q <= 1'b0;
            pa_q      <= '0;
            hit_q     <= 1'b0;
            err_q     <= 1'b0;
        end else begin
            if (flush_en && st_q != ST_IDLE) flushed_q <= 1'b1;
            unique case (st_q)
                ST_IDLE: if (req_valid) begin
                    va_q      <= req_vaddr;
                    sid_q     <= req_sid;
                    flushed_q <= 1'b0;
                    st_q      <= ST_LOOKUP;
                end
                ST_LOOKUP: if (tlb_hit && !bypass) begin
                    pa_q  <= {tlb_pfn, va_q[OFF_W-1:0]};
                    hit_q <= 1'b1;
                    err_q <= 1'b0;
                    st_q  <= ST_RESP;
                end else begin
                    st_q <= ST_L1;
                end
                ST_L1, ST_L2: begin
                    if (mem_rd_valid && mem_rd_ready) issued_q <= 1'b1;
                    if (data_in) begin
                        issued_q <= 1'b0;
                        hit_q    <= 1'b0;
                        if (mem_rsp_err) begin
                            pa_q  <= '0;
                            err_q <= 1'b1;
                            st_q  <= ST_RESP;
                        end else if (st_q == ST_L1) begin
                            l1_pfn_q <= mem_rsp_data[PFN_W-1:0];
                            st_q     <= ST_L2;
                        end else begin
                            pa_q  <= {mem_rsp_data[PFN_W-1:0], va_q[OFF_W-1:0]};
                            err_q <= 1'b0;
                            st_q  <= ST_RESP;
                        end
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign req_ready    = (st_q == ST_IDLE);
    assign rsp_valid    = (st_q == ST_RESP);
    assign rsp_paddr    = pa_q;
    assign rsp_hit      = hit_q;
    assign rsp_err      = err_q;
    assign mem_rd_valid = (st_q == ST_L1 || st_q == ST_L2) && !issued_q;
    assign mem_rd_addr  = (st_q == ST_L1)
                          ? entry_addr(base_pfn, va_q[VA_W-1:VA_W-IDX_W])
                          : entry_addr(l1_pfn_q, va_q[VA_W-IDX_W-1:OFF_W]);

    // R9: no second read before the first one's data
    assert_one_read_R9: assert property (@(posedge clk) disable iff (rst)
        (mem_rd_valid && mem_rd_ready) |=> !mem_rd_valid);
    // R2: a stalled read keeps its address
    assert_addr_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (mem_rd_valid && !mem_rd_ready && !reg_wr) |=> (mem_rd_valid && $stable(mem_rd_addr)));
    // R4: response lasts one cycle and the block is then idle
    assert_rsp_pulse_R4: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> (!rsp_valid && req_ready));
    // R5: a cached answer follows no memory read
    assert_hit_nomem_R5: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_hit) |-> !$past(mem_rd_valid));
    // R10: with the cache off no answer is a hit
    assert_bypass_nohit_R10: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_hit) |-> !$past(bypass));
endmodule

// File: tb/pgw_top_tb.sv
`timescale 1ns/1ps
module pgw_top_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic [4:0]  req_sid = '0;
    logic        rsp_valid;
    logic [38:0] rsp_paddr;
    logic        rsp_hit;
    logic        rsp_err;
    logic        mem_rd_valid;
    logic        mem_rd_ready = 1'b0;
    logic [38:0] mem_rd_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        mem_rsp_err = 1'b0;

    int n_run = 0;
    int n_fail = 0;

    logic        m_valid [8];
    logic [19:0] m_vpn   [8];
    logic [26:0] m_pfn   [8];
    logic [4:0]  m_sid   [8];
    int          m_ptr = 0;
    logic [26:0] m_base = '0;
    logic        m_bypass = 1'b0;

    always #2 clk = ~clk;

    pgw_top u_dut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
        .req_sid(req_sid), .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr),
        .rsp_hit(rsp_hit), .rsp_err(rsp_err), .mem_rd_valid(mem_rd_valid),
        .mem_rd_ready(mem_rd_ready), .mem_rd_addr(mem_rd_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .mem_rsp_err(mem_rsp_err)
    );

    function automatic logic [31:0] pte_of(input logic [38:0] a);
        logic [31:0] x;
        x = a[31:0] ^ {a[38:32], 25'd0};
        return (x * 32'h9E37_79B1) ^ 32'hA5C3_0F17;
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic model_flush(input logic [31:0] mask);
        for (int i = 0; i < 8; i++)
            if (m_valid[i] && mask[m_sid[i]]) m_valid[i] = 1'b0;
    endtask

    task automatic reg_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b0;
        if (a == 4'h0) model_flush(d);
        if (a == 4'h4) m_base = d[26:0];
        if (a == 4'h8) m_bypass = d[0];
    endtask

    task automatic reg_check(input logic [3:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        reg_addr = a;
        #1;
        check(tag, reg_rdata, exp);
    endtask

    // Serve one outstanding table read; returns at the falling edge after data.
    task automatic serve(input int stall, input int lat, input logic [31:0] data,
                         input logic err, input logic inv, input logic [31:0] mask);
        for (int k = 0; k < stall; k++) begin
            @(posedge clk);
            @(negedge clk);
            check("R9 read held while stalled", mem_rd_valid, 1);
        end
        mem_rd_ready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        mem_rd_ready = 1'b0;
        check("R9 no read after accept", mem_rd_valid, 0);
        for (int k = 0; k < lat; k++) begin
            if (inv && k == 0) begin
                reg_wr = 1'b1; reg_addr = 4'h0; reg_wdata = mask;
            end
            @(posedge clk);
            @(negedge clk);
            if (inv && k == 0) begin
                reg_wr = 1'b0;
                model_flush(mask);
            end
            check("R9 no read while waiting", mem_rd_valid, 0);
        end
        mem_rsp_valid = 1'b1; mem_rsp_data = data; mem_rsp_err = err;
        @(posedge clk);
        @(negedge clk);
        mem_rsp_valid = 1'b0; mem_rsp_err = 1'b0;
    endtask

    task automatic do_req(input string tag, input logic [31:0] va, input logic [4:0] sid,
                          input int stall, input int lat, input logic e1_err,
                          input logic e2_err, input logic inv, input logic [31:0] mask);
        logic        exp_hit;
        logic [26:0] hpfn;
        logic [38:0] a1;
        logic [38:0] a2;
        logic [31:0] e1;
        logic [31:0] e2;
        exp_hit = 1'b0;
        hpfn    = '0;
        if (!m_bypass)
            for (int i = 0; i < 8; i++)
                if (m_valid[i] && m_vpn[i] == va[31:12]) begin
                    exp_hit = 1'b1; hpfn = m_pfn[i];
                end
        @(negedge clk);
        check("R1 idle before request", req_ready, 1);
        req_valid = 1'b1; req_vaddr = va; req_sid = sid;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        check("R5 lookup cycle quiet", {rsp_valid, mem_rd_valid}, 0);
        if (exp_hit) begin
            @(negedge clk);
            check({tag, " hit response"}, {rsp_valid, rsp_hit, rsp_err, mem_rd_valid, rsp_paddr},
                  {4'b1100, hpfn, va[11:0]});
        end else begin
            a1 = {m_base, va[31:22], 2'b00};
            e1 = pte_of(a1);
            @(negedge clk);
            check("R2 first read address", {mem_rd_valid, mem_rd_addr}, {1'b1, a1});
            serve(stall, lat, e1, e1_err, inv && e1_err, mask);
            if (e1_err) begin
                check({tag, " R11 error after first fetch"},
                      {rsp_valid, rsp_err, rsp_hit, rsp_paddr}, {3'b110, 39'd0});
            end else begin
                a2 = {e1[26:0], va[21:12], 2'b00};
                e2 = pte_of(a2);
                check("R3 second read address", {mem_rd_valid, mem_rd_addr}, {1'b1, a2});
                serve(stall, lat, e2, e2_err, inv, mask);
                if (e2_err)
                    check({tag, " R11 error after second fetch"},
                          {rsp_valid, rsp_err, rsp_hit, rsp_paddr}, {3'b110, 39'd0});
                else
                    check({tag, " R4 walk response"},
                          {rsp_valid, rsp_err, rsp_hit, rsp_paddr}, {3'b100, e2[26:0], va[11:0]});
                if (!e2_err && !inv && !m_bypass) begin
                    m_valid[m_ptr] = 1'b1;
                    m_vpn[m_ptr]   = va[31:12];
                    m_pfn[m_ptr]   = e2[26:0];
                    m_sid[m_ptr]   = sid;
                    m_ptr = (m_ptr + 1) % 8;
                end
            end
        end
        @(negedge clk);
        check("R4 single-cycle response", {rsp_valid, req_ready}, 2'b01);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL R9 watchdog: actual 150000 cycles expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 8; i++) begin
            m_valid[i] = 1'b0; m_vpn[i] = '0; m_pfn[i] = '0; m_sid[i] = '0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 reset outputs", {req_ready, mem_rd_valid, rsp_valid}, 3'b100);
        reg_check(4'h4, 32'h0, "R1 base after reset");
        reg_check(4'h8, 32'h0, "R1 config after reset");

        reg_write(4'h4, 32'hFFFF_FFFF);
        reg_check(4'h4, 32'h07FF_FFFF, "R12 base width");
        reg_write(4'h8, 32'hA5A5_A5A4);
        reg_check(4'h8, 32'hA5A5_A5A4, "R12 config readback");
        reg_check(4'h0, 32'h0, "R12 flush reads zero");
        reg_write(4'h8, 32'h0);
        reg_write(4'h4, 32'h0001_2345);

        do_req("R1 first miss", 32'h1234_5678, 5'd0, 2, 3, 0, 0, 0, 0);
        do_req("R5 same page", 32'h1234_5ABC, 5'd0, 0, 1, 0, 0, 0, 0);

        for (int p = 1; p < 8; p++)
            do_req("R6 fill", 32'h4000_0000 + p * 32'h0040_1000, 5'd1, p % 3, 1 + p % 2, 0, 0, 0, 0);
        do_req("R6 all cached", 32'h1234_5000, 5'd0, 0, 1, 0, 0, 0, 0);
        do_req("R6 ninth page", 32'h7777_7000, 5'd1, 0, 1, 0, 0, 0, 0);
        do_req("R6 first evicted", 32'h1234_5010, 5'd0, 0, 1, 0, 0, 0, 0);
        do_req("R6 second slot evicted", 32'h4040_1000, 5'd1, 0, 1, 0, 0, 0, 0);

        do_req("R7 fill sid3", 32'h0300_3000, 5'd3, 0, 1, 0, 0, 0, 0);
        do_req("R7 fill sid7", 32'h0700_7000, 5'd7, 0, 1, 0, 0, 0, 0);
        reg_write(4'h0, 32'h0000_0008);
        do_req("R7 sid3 dropped", 32'h0300_3004, 5'd3, 0, 1, 0, 0, 0, 0);
        do_req("R7 sid7 kept", 32'h0700_7008, 5'd7, 0, 1, 0, 0, 0, 0);
        reg_write(4'h0, 32'h0);
        do_req("R7 zero mask", 32'h0700_700C, 5'd7, 0, 1, 0, 0, 0, 0);
        reg_write(4'h0, 32'hFFFF_FFFF);
        do_req("R7 all dropped", 32'h0700_7010, 5'd7, 0, 1, 0, 0, 0, 0);

        do_req("R8 flush during walk", 32'h0888_8123, 5'd0, 1, 2, 0, 0, 1, 32'h0000_0100);
        do_req("R8 not cached", 32'h0888_8456, 5'd0, 0, 1, 0, 0, 0, 0);

        reg_write(4'h8, 32'h1);
        do_req("R10 bypass walks", 32'h0888_8000, 5'd0, 0, 1, 0, 0, 0, 0);
        do_req("R10 bypass new page", 32'h0999_9000, 5'd0, 0, 1, 0, 0, 0, 0);
        do_req("R10 bypass no fill", 32'h0999_9004, 5'd0, 0, 1, 0, 0, 0, 0);
        reg_write(4'h8, 32'h0);
        do_req("R10 earlier entry kept", 32'h0888_8FFC, 5'd0, 0, 1, 0, 0, 0, 0);

        do_req("R11 first fetch", 32'h0AAA_A000, 5'd2, 0, 2, 1, 0, 0, 0);
        do_req("R11 second fetch", 32'h0AAA_A000, 5'd2, 1, 1, 0, 1, 0, 0);
        do_req("R11 not cached", 32'h0AAA_A040, 5'd2, 0, 1, 0, 0, 0, 0);

        reg_write(4'h4, 32'h0765_4321);
        do_req("R2 new base", 32'hFFC0_1234, 5'd4, 3, 1, 0, 0, 0, 0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule